// File: doc/BRIEF.md
# Chained Descriptor DMA Channel

This block is one memory-to-memory DMA channel. It moves a programmed number of units, each of the source width, from a source address to a destination address. Each unit is read into a one-beat holding buffer and then written out. Only one bus request is in flight at any time. The source and destination addresses each step independently: they count up, count down or stay put, always by the unit size in bytes. Beats are grouped into bursts. A burst is either a power of two long or a custom length, and the final beat of each burst is flagged on the bus.

When the unit count is reached, the channel does one of three things. In loop mode it replays the same transfer from its original addresses. If a non-zero link address is held, it reads an eight-word descriptor from that address, takes its control, size, source, destination and next-link words, and carries on. Otherwise it stops. The channel pulses an event for each of these: completion, the halfway point, a bus or alignment error, and an abort. The configuration inputs are sampled on a start pulse while the channel is idle.

Top module: `ldma_channel`

## Requirements
- R1: The state output uses these codes: idle 0, read issue 1, read wait 2, write issue 3, write wait 4, descriptor fetch 5, terminal 6, wind-down 7. `dma_idle` is high only in code 0. Reset returns to code 0 with no request and the channel disabled.
- R2: Each unit is read from the current source address, then written to the current destination address. The write carries the read data unchanged. `bus_size` equals the width code: 0 byte, 1 half-word, 2 word, 3 double-word.
- R3: Control word bits [3:2] select the source address mode and bits [5:4] select the destination address mode: 0 increments, 1 decrements, 2 or 3 holds. After each unit the address moves by 1 << width bytes. The width code sits in bits [1:0].
- R4: Bits [9:6] hold the burst code. With bit [10] clear, a burst is 2^code beats, and codes above 10 are capped at 1024. `bus_last` is high on the last beat of each burst and on the final unit.
- R5: With bit [10] set, a burst is code+1 beats.
- R6: At terminal count, after exactly `size` reads and writes, `evt_done` pulses. With no loop and a zero link the channel then disables and returns to idle.
- R7: `evt_half` pulses once per pass, after the write that brings the moved count to size>>1. It does not pulse when size is below 2.
- R8: With a non-zero link at terminal count, the channel reads eight 32-bit words (`bus_size` 2) at link, link+4, …, link+28. Word 0 is control, 1 size, 2 source, 4 destination, 6 next link. Words 3, 5 and 7 are read and ignored. The transfer then restarts with those values. A zero link ends the chain.
- R9: With loop bit [11] set, terminal count restarts the transfer from the original source and destination addresses. Loop mode takes precedence over the link.
- R10: An abort is honoured at the next request boundary. It issues no further request, pulses `evt_abort`, disables the channel and returns to idle. An abort raised while idle has no effect.
- R11: An error response on a data read, a data write or a descriptor read pulses `evt_err`, disables the channel and returns to idle without further requests.
- R12: A source or destination address not aligned to the width is rejected. This applies at start and after a descriptor fetch. The channel pulses `evt_err` and makes no data access.
- R13: A new request is never issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled in idle |
| abort | input | 1 | Abort request |
| cfg_ctrl | input | 32 | Control word (width, address modes, burst, loop) |
| cfg_size | input | 32 | Unit count |
| cfg_src | input | AW | Source address |
| cfg_dst | input | AW | Destination address |
| cfg_next | input | AW | Link address, zero for none |
| bus_req | output | 1 | Request valid for one cycle |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | AW | Request address |
| bus_size | output | 2 | Access width code |
| bus_last | output | 1 | Last beat of burst |
| bus_wdata | output | DW | Write data |
| bus_resp | input | 1 | Response valid |
| bus_err | input | 1 | Response is an error |
| bus_rdata | input | DW | Read data |
| evt_done | output | 1 | Terminal-count pulse |
| evt_half | output | 1 | Halfway pulse |
| evt_err | output | 1 | Error pulse |
| evt_abort | output | 1 | Abort pulse |
| ch_enable | output | 1 | Channel enabled |
| dma_idle | output | 1 | Engine idle |
| dma_state | output | 3 | Engine state code |

## Verification
The bench runs every address mode against every width and checks the reversed direction in particular. A design that stepped by one byte, or moved fixed addresses, would write to the wrong places. Burst boundaries are checked under both the power-of-two and the custom rule. An off-by-one in the burst counter would move or drop the `bus_last` flags.

A two-descriptor chain is traced word by word. A design that mis-indexed a descriptor field, or that checked the link before fetching, would send the later segments to the wrong addresses. Loop mode is interrupted by an abort, which exposes a restart from stepped addresses and an abort that does not stop the channel. Errors are injected on a data read and on a descriptor word, and misaligned starts are tried. A design that kept running, or that touched the bus after rejecting a start, would show extra accesses.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RDACK = 3'd2,
    ST_WR    = 3'd3,
    ST_WRACK = 3'd4,
    ST_LINK  = 3'd5,
    ST_END   = 3'd6,
    ST_ENDW  = 3'd7
  } st_e;

  // control word layout, LSB first: width, src mode, dst mode, burst code, custom, loop
  typedef struct packed {
    logic       loop;
    logic       bcust;
    logic [3:0] bcode;
    logic [1:0] dctl;
    logic [1:0] sctl;
    logic [1:0] width;
  } ctrl_t;

  localparam int DESC_WORDS = 8;
  localparam logic [2:0] DWI_CTRL = 3'd0;
  localparam logic [2:0] DWI_SIZE = 3'd1;
  localparam logic [2:0] DWI_SRC  = 3'd2;
  localparam logic [2:0] DWI_DST  = 3'd4;
  localparam logic [2:0] DWI_NEXT = 3'd6;

  function automatic ctrl_t decode_ctrl(input logic [31:0] w);
    return ctrl_t'(w[11:0]);
  endfunction

endpackage

// File: rtl/ldma_addr_unit.sv
module ldma_addr_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ctl,
  input  logic [1:0]    width,
  output logic [AW-1:0] addr_next,
  output logic          misaligned
);
  logic [AW-1:0] step;

  always_comb begin
    step = {{(AW-1){1'b0}}, 1'b1} << width;
    case (ctl)
      2'd0:    addr_next = addr + step;
      2'd1:    addr_next = addr - step;
      default: addr_next = addr;
    endcase
    misaligned = |(addr & (step - {{(AW-1){1'b0}}, 1'b1}));
  end
endmodule

// File: rtl/ldma_burst_len.sv
module ldma_burst_len #(
  parameter int MAX_BCODE = 10,
  parameter int LEN_W     = MAX_BCODE + 1
) (
  input  logic [3:0]       code,
  input  logic             custom,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    if (custom)
      len = LEN_W'(code) + LEN_W'(1);
    else if (int'(code) > MAX_BCODE)
      len = LEN_W'(1) << MAX_BCODE;
    else
      len = LEN_W'(1) << code;
  end
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int CNT_W     = 16,
  parameter int MAX_BCODE = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [31:0]   cfg_ctrl,
  input  logic [31:0]   cfg_size,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [AW-1:0] cfg_next,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_last,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_resp,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          evt_done,
  output logic          evt_half,
  output logic          evt_err,
  output logic          evt_abort,
  output logic          ch_enable,
  output logic          dma_idle,
  output logic [2:0]    dma_state
);
  import ldma_pkg::*;

  localparam int LEN_W = MAX_BCODE + 1;
  localparam int IDX_W = $clog2(DESC_WORDS);

  st_e              state;
  ctrl_t            ctl, cfg_c;
  logic [CNT_W-1:0] size_q, moved_q, moved_n;
  logic [AW-1:0]    src_q, dst_q, osrc_q, odst_q, next_q, lbase_q;
  logic [LEN_W-1:0] bcnt_q, blen;
  logic [IDX_W-1:0] lidx_q;
  logic             lpend_q, abort_q, en_q, beat_last;
  logic [DW-1:0]    rbuf_q;
  logic [AW-1:0]    au_addr [2];
  logic [AW-1:0]    au_next [2];
  logic [1:0]       au_ctl  [2];
  logic [1:0]       au_mis;
  logic [1:0]       chk_w;

  assign cfg_c = decode_ctrl(cfg_ctrl);

  // in idle the units vet the incoming configuration; otherwise they step the live addresses
  always_comb begin
    chk_w      = (state == ST_IDLE) ? cfg_c.width : ctl.width;
    au_addr[0] = (state == ST_IDLE) ? cfg_src : src_q;
    au_addr[1] = (state == ST_IDLE) ? cfg_dst : dst_q;
    au_ctl[0]  = ctl.sctl;
    au_ctl[1]  = ctl.dctl;
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    ldma_addr_unit #(.AW(AW)) u_au (
      .addr(au_addr[s]), .ctl(au_ctl[s]), .width(chk_w),
      .addr_next(au_next[s]), .misaligned(au_mis[s])
    );
  end

  ldma_burst_len #(.MAX_BCODE(MAX_BCODE), .LEN_W(LEN_W)) u_blen (
    .code(ctl.bcode), .custom(ctl.bcust), .len(blen)
  );

  assign moved_n   = moved_q + CNT_W'(1);
  assign beat_last = (bcnt_q == blen - LEN_W'(1)) || (moved_n == size_q);

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = src_q;
    bus_size  = ctl.width;
    bus_last  = 1'b0;
    bus_wdata = rbuf_q;
    case (state)
      ST_RD: begin
        bus_req  = !abort_q;
        bus_last = beat_last;
      end
      ST_WR: begin
        bus_req  = !abort_q;
        bus_we   = 1'b1;
        bus_addr = dst_q;
        bus_last = beat_last;
      end
      ST_LINK: begin
        bus_req  = !lpend_q && !abort_q;
        bus_addr = lbase_q + AW'({lidx_q, 2'b00});
        bus_size = 2'd2;
        bus_last = (lidx_q == IDX_W'(DESC_WORDS - 1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   ctl <= '0;      size_q <= '0;  moved_q <= '0;
      src_q <= '0;        dst_q <= '0;    osrc_q <= '0;  odst_q <= '0;
      next_q <= '0;       lbase_q <= '0;  bcnt_q <= '0;  lidx_q <= '0;
      lpend_q <= 1'b0;    abort_q <= 1'b0; en_q <= 1'b0; rbuf_q <= '0;
      evt_done <= 1'b0;   evt_half <= 1'b0; evt_err <= 1'b0; evt_abort <= 1'b0;
    end else begin
      evt_done <= 1'b0; evt_half <= 1'b0; evt_err <= 1'b0; evt_abort <= 1'b0;
      if (state == ST_IDLE) abort_q <= 1'b0;
      else if (abort)       abort_q <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          ctl <= cfg_c;  size_q <= cfg_size[CNT_W-1:0];
          src_q <= cfg_src;  osrc_q <= cfg_src;
          dst_q <= cfg_dst;  odst_q <= cfg_dst;
          next_q <= cfg_next;  moved_q <= '0;  bcnt_q <= '0;  en_q <= 1'b1;
          if (|au_mis) begin
            evt_err <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
          end else if (cfg_size[CNT_W-1:0] == '0) state <= ST_END;
          else state <= ST_RD;
        end
        ST_RD, ST_WR: begin
          if (abort_q) begin
            evt_abort <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
          end else state <= (state == ST_RD) ? ST_RDACK : ST_WRACK;
        end
        ST_RDACK: if (bus_resp) begin
          if (bus_err) begin
            evt_err <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
          end else begin
            rbuf_q <= bus_rdata; state <= ST_WR;
          end
        end
        ST_WRACK: if (bus_resp) begin
          if (bus_err) begin
            evt_err <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
          end else begin
            src_q   <= au_next[0];
            dst_q   <= au_next[1];
            moved_q <= moved_n;
            bcnt_q  <= beat_last ? '0 : bcnt_q + LEN_W'(1);
            if (size_q > CNT_W'(1) && moved_n == (size_q >> 1)) evt_half <= 1'b1;
            state <= (moved_n == size_q) ? ST_END : ST_RD;
          end
        end
        ST_END: begin
          evt_done <= 1'b1;
          if (ctl.loop && size_q != '0) begin
            src_q <= osrc_q; dst_q <= odst_q; moved_q <= '0; bcnt_q <= '0;
            state <= ST_RD;
          end else if (next_q != '0) begin
            lbase_q <= next_q; lidx_q <= '0; lpend_q <= 1'b0; state <= ST_LINK;
          end else begin
            en_q <= 1'b0; state <= ST_ENDW;
          end
        end
        ST_LINK: begin
          if (!lpend_q) begin
            if (abort_q) begin
              evt_abort <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
            end else lpend_q <= 1'b1;
          end else if (bus_resp) begin
            if (bus_err) begin
              evt_err <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
            end else begin
              lpend_q <= 1'b0;
              lidx_q  <= lidx_q + IDX_W'(1);
              case (lidx_q)
                DWI_CTRL: ctl    <= decode_ctrl(bus_rdata[31:0]);
                DWI_SIZE: size_q <= bus_rdata[CNT_W-1:0];
                DWI_SRC:  begin src_q <= AW'(bus_rdata[31:0]); osrc_q <= AW'(bus_rdata[31:0]); end
                DWI_DST:  begin dst_q <= AW'(bus_rdata[31:0]); odst_q <= AW'(bus_rdata[31:0]); end
                DWI_NEXT: next_q <= AW'(bus_rdata[31:0]);
                default: ;
              endcase
              if (lidx_q == IDX_W'(DESC_WORDS - 1)) begin
                moved_q <= '0; bcnt_q <= '0;
                if (|au_mis) begin
                  evt_err <= 1'b1; en_q <= 1'b0; state <= ST_ENDW;
                end else if (size_q == '0) state <= ST_END;
                else state <= ST_RD;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ch_enable = en_q;
  assign dma_idle  = (state == ST_IDLE);
  assign dma_state = state;

  // R13
  one_req_chk: assert property (@(posedge clk) disable iff (rst) bus_req |=> !bus_req);
  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> $past(bus_resp && !bus_err));
  // R4
  burst_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD || state == ST_WR) |-> (bcnt_q < blen));
  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    evt_abort |=> (dma_idle && !ch_enable));
  // R11
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    evt_err |=> (dma_idle && !ch_enable));
  // R12
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && (|au_mis)) |=> (state == ST_ENDW && !bus_req));
endmodule

// File: tb/ldma_channel_tb_top.sv
`timescale 1ns/1ps
module ldma_channel_tb_top;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [31:0] DBASE = 32'h8000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, abort = 1'b0;
  logic [31:0] cfg_ctrl = '0, cfg_size = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0, cfg_next = '0;
  logic bus_req, bus_we, bus_last, bus_resp, bus_err;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic evt_done, evt_half, evt_err, evt_abort, ch_enable, dma_idle;
  logic [2:0] dma_state;

  always #5 clk = ~clk;

  ldma_channel #(.AW(AW), .DW(DW)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int n_rd, n_wr, n_done, n_half, n_err, n_abort, half_at, r13_bad;
  int resp_lat = 1;
  logic err_on = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic [AW-1:0] rd_addr [64];
  logic [AW-1:0] wr_addr [64];
  logic [DW-1:0] wr_data [64];
  logic [1:0]    wr_size [64];
  logic          wr_last [64];
  logic [31:0]   desc [16];

  // ctrl12 | size16 | src32 | dst32 | expected final dst address32
  localparam logic [123:0] VEC [4] = '{
    {12'h042, 16'd4, 32'h0000_0100, 32'h0000_2000, 32'h0000_200C},
    {12'h484, 16'd5, 32'h0000_01F0, 32'h0000_3000, 32'h0000_3004},
    {12'h019, 16'd3, 32'h0000_0400, 32'h0000_5006, 32'h0000_5002},
    {12'h0A3, 16'd6, 32'h0000_0800, 32'h0000_6000, 32'h0000_6000}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ea(input logic [AW-1:0] b, input logic [1:0] m,
                                       input logic [1:0] w, input int i);
    if (m == 2'd0) return b + AW'(i << w);
    if (m == 2'd1) return b - AW'(i << w);
    return b;
  endfunction

  function automatic logic [DW-1:0] memrd(input logic [AW-1:0] a);
    if (a >= DBASE && a < DBASE + 32'h40) return {32'h0, desc[(a - DBASE) >> 2]};
    return {~a, a};
  endfunction

  // bus responder: logs each request, answers resp_lat negedges later
  initial begin
    bus_resp = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    forever begin
      logic [AW-1:0] a;
      @(negedge clk);
      bus_resp = 1'b0; bus_err = 1'b0;
      if (bus_req) begin
        a = bus_addr;
        if (bus_we) begin
          if (n_wr < 64) begin
            wr_addr[n_wr] = a; wr_data[n_wr] = bus_wdata;
            wr_size[n_wr] = bus_size; wr_last[n_wr] = bus_last;
          end
          n_wr++;
        end else begin
          if (n_rd < 64) rd_addr[n_rd] = a;
          n_rd++;
        end
        for (int k = 0; k < resp_lat; k++) begin
          @(negedge clk);
          if (bus_req) r13_bad++;
        end
        bus_resp = 1'b1;
        bus_err = err_on && (a == err_addr);
        bus_rdata = memrd(a);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (evt_done) n_done++;
    if (evt_half) begin n_half++; half_at = n_wr; end
    if (evt_err) n_err++;
    if (evt_abort) n_abort++;
  end

  task automatic kick(input logic [31:0] c, input logic [31:0] sz, input logic [AW-1:0] s,
                      input logic [AW-1:0] d, input logic [AW-1:0] nx);
    n_rd = 0; n_wr = 0; n_done = 0; n_half = 0; n_err = 0; n_abort = 0; half_at = -1; r13_bad = 0;
    @(negedge clk);
    cfg_ctrl = c; cfg_size = sz; cfg_src = s; cfg_dst = d; cfg_next = nx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int cyc = 0;
    while (!dma_idle && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc < 5000, "watchdog (return to idle)", 64'(cyc), 64'd5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) desc[i] = 32'h0;
    desc[0] = 32'h002; desc[1] = 32'd2; desc[2] = 32'hA00; desc[4] = 32'hB00; desc[6] = 32'h8020;
    desc[3] = 32'hDEAD; desc[5] = 32'hBEEF; desc[7] = 32'hF00D;
    desc[8] = 32'h000; desc[9] = 32'd1; desc[10] = 32'hC01; desc[12] = 32'hD03; desc[14] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dma_idle && dma_state == 3'd0 && !bus_req && !ch_enable, "R1 reset state",
        {dma_idle, dma_state, bus_req, ch_enable}, 64'b1_000_0_0);

    // table of transfers
    for (int r = 0; r < 4; r++) begin
      logic [123:0] v;
      logic [11:0] c;
      int sz, bl, e_a, e_d, e_l;
      logic [AW-1:0] s;
      v = VEC[r]; c = v[123:112]; sz = int'(v[111:96]);
      bl = c[10] ? int'(c[9:6]) + 1 : (1 << c[9:6]);
      resp_lat = 1 + (r % 2);
      kick({20'h0, c}, 32'(sz), v[95:64], v[63:32], '0);
      // R1 leaves idle into read issue
      chk(dma_state == 3'd1 && !dma_idle, "R1 state after start", 64'(dma_state), 64'd1);
      @(negedge clk);
      chk(dma_state == 3'd2, "R1 read wait code", 64'(dma_state), 64'd2);
      wait_idle();
      chk(n_wr == sz && n_rd == sz, "R6 beat count", 64'(n_wr), 64'(sz));
      chk(n_done == 1 && !ch_enable, "R6 done and disabled", 64'(n_done), 64'd1);
      e_a = 0; e_d = 0; e_l = 0;
      for (int i = 0; i < sz; i++) begin
        s = ea(v[95:64], c[3:2], c[1:0], i);
        if (rd_addr[i] != s || wr_addr[i] != ea(v[63:32], c[5:4], c[1:0], i)) e_a++;
        if (wr_data[i] != {~s, s} || wr_size[i] != c[1:0]) e_d++;
        if (wr_last[i] != (((i + 1) % bl == 0) || (i == sz - 1))) e_l++;
      end
      chk(e_a == 0, "R3 address stepping", 64'(e_a), 64'd0);
      chk(e_d == 0, "R2 write data and size", 64'(e_d), 64'd0);
      chk(e_l == 0, c[10] ? "R5 custom burst last flags" : "R4 burst last flags", 64'(e_l), 64'd0);
      chk(wr_addr[sz-1] == v[31:0], "R3 final destination", 64'(wr_addr[sz-1]), 64'(v[31:0]));
      chk(n_half == 1 && half_at == sz / 2, "R7 half event", 64'(half_at), 64'(sz / 2));
      chk(r13_bad == 0, "R13 single outstanding", 64'(r13_bad), 64'd0);
    end
    resp_lat = 1;

    // R8 two-descriptor chain
    kick(32'h002, 32'd1, 32'h100, 32'h7000, DBASE);
    wait_idle();
    chk(n_done == 3 && n_wr == 4 && n_rd == 20, "R8 chain counts", {32'(n_done), 32'(n_rd)}, {32'd3, 32'd20});
    begin
      int e = 0;
      for (int k = 0; k < 8; k++) begin
        if (rd_addr[1 + k] != DBASE + 32'(4 * k)) e++;
        if (rd_addr[11 + k] != 32'h8020 + 32'(4 * k)) e++;
      end
      chk(e == 0, "R8 descriptor word addresses", 64'(e), 64'd0);
    end
    chk(rd_addr[9] == 32'hA00 && rd_addr[10] == 32'hA04 && rd_addr[19] == 32'hC01,
        "R8 chained sources", 64'(rd_addr[19]), 64'hC01);
    chk(wr_addr[1] == 32'hB00 && wr_addr[2] == 32'hB04 && wr_addr[3] == 32'hD03 && wr_size[3] == 2'd0,
        "R8 chained destinations", 64'(wr_addr[3]), 64'hD03);
    chk(n_half == 1 && !ch_enable, "R8 zero link stops", 64'(n_half), 64'd1);

    // R10 abort while idle ignored
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    kick(32'h002, 32'd1, 32'h100, 32'h200, '0);
    wait_idle();
    chk(n_abort == 0 && n_done == 1 && n_wr == 1, "R10 idle abort ignored", 64'(n_abort), 64'd0);

    // R9 loop then R10 abort
    kick(32'h802, 32'd2, 32'h100, 32'h200, DBASE);
    begin
      int cyc = 0;
      while (n_wr < 5 && cyc < 2000) begin @(negedge clk); cyc++; end
    end
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_idle();
    chk(rd_addr[2] == 32'h100 && wr_addr[2] == 32'h200 && wr_addr[3] == 32'h204,
        "R9 loop restarts at origin", 64'(wr_addr[2]), 64'h200);
    chk(n_done >= 2 && n_half >= 2, "R9 loop repeats passes", 64'(n_done), 64'd2);
    chk(n_abort == 1 && !ch_enable && n_wr <= 6, "R10 abort stops channel", 64'(n_abort), 64'd1);

    // R11 error on data read
    err_on = 1'b1; err_addr = 32'h304;
    kick(32'h002, 32'd4, 32'h300, 32'h900, '0);
    wait_idle();
    chk(n_err == 1 && n_done == 0 && n_wr == 1 && n_rd == 2 && !ch_enable,
        "R11 read error stops", {32'(n_err), 32'(n_wr)}, {32'd1, 32'd1});
    // R11 error on descriptor word
    err_addr = DBASE + 32'h8;
    kick(32'h002, 32'd1, 32'h300, 32'h900, DBASE);
    wait_idle();
    chk(n_err == 1 && n_done == 1 && n_rd == 4 && n_wr == 1, "R11 descriptor error stops",
        64'(n_rd), 64'd4);
    err_on = 1'b0;

    // R12 misaligned source and destination
    kick(32'h002, 32'd4, 32'h102, 32'h900, '0);
    wait_idle();
    chk(n_err == 1 && n_rd == 0 && n_wr == 0 && !ch_enable, "R12 misaligned source", 64'(n_rd), 64'd0);
    kick(32'h001, 32'd2, 32'h100, 32'h901, '0);
    wait_idle();
    chk(n_err == 1 && n_rd == 0 && n_done == 0, "R12 misaligned destination", 64'(n_err), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule